// File: doc/BRIEF.md
# Transmit Slot Ring Tracker

This block keeps account of a small ring of transmit slots that sits between a frame producer and the per-slot completion status reported by a transmit engine. Each accepted frame is assigned the next slot in ring order and produces a command word for that slot. The command word carries the frame length and the current early-transmit threshold. Frames shorter than the minimum Ethernet length are padded up to it, because the engine downstream does not pad.

Completions are consumed strictly oldest first, at most one slot per clock. The tracker decodes each finished slot's status word into error, carrier-loss, late-window, FIFO-underrun, collision, byte and packet totals. It raises the early-transmit threshold in fixed steps whenever a good frame reports an underrun, up to a cap. When a frame is aborted it emits a one-cycle request to clear the abort condition.

The ring occupancy is tracked by a three-state machine:
- `RING_EMPTY`: no slot is outstanding.
- `RING_PARTIAL`: some slots are outstanding, but not all.
- `RING_FULL`: every slot is outstanding, and producer requests are refused.

Its transitions are:
- fill: `RING_EMPTY` to `RING_PARTIAL` on an accept.
- top-up: `RING_PARTIAL` to `RING_FULL` on an accept with no retire while one slot is free.
- drain: `RING_PARTIAL` to `RING_EMPTY` on a retire with no accept while one slot is outstanding.
- release: `RING_FULL` to `RING_PARTIAL` on any retire.

The slot count must be a power of two.

Top module: `tx_slot_tracker`

## Requirements
- R1: After reset the ring is empty, `q_full`, `cmd_valid` and `clear_abort` are low, and every counter reads zero.
- R2: A request accepted at a clock edge produces a one-cycle `cmd_valid` after that edge. `cmd_slot` equals the number of frames accepted before it modulo SLOTS.
- R3: The length field of the command word, bits [10:0], equals max(`q_len`, 60).
- R4: The command word is the padded length ORed with the threshold field at bits [21:16]. The threshold field starts at ((INIT_THRESH << 11) & 0x003f0000) >> 16, which is 8 for the default of 256.
- R5: `q_full` is high exactly when accepted minus retired frames equals SLOTS. A request made while it is high is ignored: no command is issued and no slot is consumed.
- R6: Only the oldest outstanding slot can retire. It retires when its status word has bit 15 (good), bit 14 (underrun) or bit 30 (aborted) set. A finished slot behind an unfinished one waits.
- R7: A retired status with bit 30 or bit 29 (late window) set takes the error path. On this path the error count increments, bit 31 (carrier lost) increments the carrier count, and bit 29 increments the window count. Bit 30 also gives a one-cycle `clear_abort`. The packet, byte and collision totals are untouched.
- R8: A retired status on the good path with bit 14 set increments the FIFO-error count. It also raises the threshold field by 2 (0x00020000 in the word) while the field is below 48 (0x00300000).
- R9: Every good-path retirement adds status bits [27:24] to the collision total and bits [10:0] to the byte total, and increments the packet count.
- R10: A retirement while `q_full` is high deasserts `q_full` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_req | input | 1 | Producer asks to queue a frame |
| q_len | input | LEN_W (11) | Frame length in bytes |
| slot_status | input | SLOTS*32 (128) | Completion status words, slot i at bits [32*i+31:32*i] |
| cmd_valid | output | 1 | A command word was issued this cycle |
| cmd_slot | output | $clog2(SLOTS) (2) | Slot the command belongs to |
| cmd_word | output | 32 | Threshold field ORed with padded length |
| q_full | output | 1 | All slots outstanding |
| clear_abort | output | 1 | One-cycle request to clear an abort |
| err_cnt | output | CNT_W (16) | Error-path retirements |
| crs_cnt | output | CNT_W (16) | Carrier-lost errors |
| owc_cnt | output | CNT_W (16) | Late-window errors |
| fifo_cnt | output | CNT_W (16) | Underrun retirements on the good path |
| coll_cnt | output | CNT_W (16) | Collision total |
| byte_cnt | output | BYTE_W (32) | Byte total |
| pkt_cnt | output | CNT_W (16) | Good-path retirements |

## Verification
The assertions assume that a slot's status word shows none of the finish bits from the clock the slot is accepted until the engine completes it. Without this, a stale status left over from the slot's previous use would retire the new frame at once. The bench keeps to this by clearing a slot's status in the same cycle it requests that slot. It writes a finish status only for a slot it knows to be outstanding. The bench never queues a frame in the same cycle as an underrun completion, so the expected threshold for each command is unambiguous.

// File: rtl/tx_trk_pkg.sv
package tx_trk_pkg;

    localparam int STAT_W   = 32;
    localparam int BIT_CRS  = 31;
    localparam int BIT_ABT  = 30;
    localparam int BIT_OWC  = 29;
    localparam int COLL_LO  = 24;
    localparam int COLL_W   = 4;
    localparam int BIT_OK   = 15;
    localparam int BIT_URUN = 14;
    localparam int BYTES_W  = 11;
    localparam int THR_LSB  = 16;
    localparam int THR_W    = 6;

    typedef enum logic [1:0] {
        RING_EMPTY   = 2'd0,
        RING_PARTIAL = 2'd1,
        RING_FULL    = 2'd2
    } ring_state_e;

    typedef struct packed {
        logic               done;
        logic               fault;
        logic               abort;
        logic               crs;
        logic               owc;
        logic               urun;
        logic [COLL_W-1:0]  coll;
        logic [BYTES_W-1:0] bytes;
    } cpl_info_t;

    function automatic cpl_info_t decode_status(input logic [STAT_W-1:0] w);
        cpl_info_t r;
        r.abort = w[BIT_ABT];
        r.owc   = w[BIT_OWC];
        r.crs   = w[BIT_CRS];
        r.urun  = w[BIT_URUN];
        r.done  = w[BIT_OK] | w[BIT_URUN] | w[BIT_ABT];
        r.fault = w[BIT_OWC] | w[BIT_ABT];
        r.coll  = w[COLL_LO +: COLL_W];
        r.bytes = w[BYTES_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/tx_ring_ctrl.sv
module tx_ring_ctrl
    import tx_trk_pkg::*;
#(
    parameter int SLOTS = 4,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int PTR_W  = SLOT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_req,
    input  logic              oldest_done,
    output logic              accept,
    output logic              retire,
    output logic [SLOT_W-1:0] prod_slot,
    output logic [SLOT_W-1:0] ret_slot,
    output logic              full
);

    ring_state_e state_q, state_d;
    logic [PTR_W-1:0] prod_q, ret_q;
    logic [PTR_W-1:0] occ;

    assign occ       = prod_q - ret_q;
    assign prod_slot = prod_q[SLOT_W-1:0];
    assign ret_slot  = ret_q[SLOT_W-1:0];

    // accept / retire decisions come from the state, not the counters
    always_comb begin
        accept = q_req && (state_q != RING_FULL);
        retire = oldest_done && (state_q != RING_EMPTY);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RING_EMPTY: begin
                if (accept)
                    state_d = (SLOTS == 1) ? RING_FULL : RING_PARTIAL;
            end
            RING_PARTIAL: begin
                if (accept && !retire && occ == PTR_W'(SLOTS - 1))
                    state_d = RING_FULL;
                else if (retire && !accept && occ == PTR_W'(1))
                    state_d = RING_EMPTY;
            end
            RING_FULL: begin
                if (retire)
                    state_d = (SLOTS == 1) ? RING_EMPTY : RING_PARTIAL;
            end
            default: state_d = RING_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RING_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
            ret_q  <= '0;
        end else begin
            if (accept) prod_q <= prod_q + PTR_W'(1);
            if (retire) ret_q  <= ret_q + PTR_W'(1);
        end
    end

    always_comb full = (state_q == RING_FULL);

    p_occ_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= PTR_W'(SLOTS));

    p_full_matches_occ_r5: assert property (@(posedge clk) disable iff (!rst_n)
        full == (occ == PTR_W'(SLOTS)));

    p_retire_frees_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (full && retire) |=> !full);

    p_in_order_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_q != $past(ret_q)) |-> (ret_q == $past(ret_q) + PTR_W'(1)));

endmodule

// File: rtl/tx_cmd_gen.sv
module tx_cmd_gen
    import tx_trk_pkg::*;
#(
    parameter int SLOTS       = 4,
    parameter int LEN_W       = 11,
    parameter int MIN_LEN     = 60,
    parameter int INIT_THRESH = 256,
    parameter int THR_STEP    = 2,
    parameter int THR_CAP     = 48,
    localparam int SLOT_W     = $clog2(SLOTS),
    localparam int INIT_FLAG  = (INIT_THRESH * 2048) & 32'h003f0000,
    localparam int INIT_FIELD = INIT_FLAG / 65536
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [LEN_W-1:0]  q_len,
    input  logic [SLOT_W-1:0] prod_slot,
    input  logic              bump,
    output logic              cmd_valid,
    output logic [SLOT_W-1:0] cmd_slot,
    output logic [STAT_W-1:0] cmd_word
);

    logic [THR_W-1:0]  thr_q;
    logic [LEN_W-1:0]  pad_len;
    logic [STAT_W-1:0] word_d;

    always_comb begin
        pad_len = (q_len < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) : q_len;
        word_d  = '0;
        word_d[THR_LSB +: THR_W] = thr_q;
        word_d[LEN_W-1:0]        = pad_len;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q <= THR_W'(INIT_FIELD);
        end else if (bump && (thr_q < THR_W'(THR_CAP))) begin
            thr_q <= thr_q + THR_W'(THR_STEP);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_slot  <= '0;
            cmd_word  <= '0;
        end else begin
            cmd_valid <= accept;
            if (accept) begin
                cmd_slot <= prod_slot;
                cmd_word <= word_d;
            end
        end
    end

    p_len_padded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_word[LEN_W-1:0] >= LEN_W'(MIN_LEN)));

    p_thr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_q != $past(thr_q)) |->
            ((thr_q == $past(thr_q) + THR_W'(THR_STEP)) && ($past(thr_q) < THR_W'(THR_CAP))));

endmodule

// File: rtl/tx_cpl_stats.sv
module tx_cpl_stats
    import tx_trk_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              retire,
    input  cpl_info_t         info,
    output logic              underrun_evt,
    output logic              clear_abort,
    output logic [CNT_W-1:0]  err_cnt,
    output logic [CNT_W-1:0]  crs_cnt,
    output logic [CNT_W-1:0]  owc_cnt,
    output logic [CNT_W-1:0]  fifo_cnt,
    output logic [CNT_W-1:0]  coll_cnt,
    output logic [BYTE_W-1:0] byte_cnt,
    output logic [CNT_W-1:0]  pkt_cnt
);

    logic bad_path, good_path;

    always_comb begin
        bad_path     = retire && info.fault;
        good_path    = retire && !info.fault;
        underrun_evt = good_path && info.urun;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clear_abort <= 1'b0;
            err_cnt     <= '0;
            crs_cnt     <= '0;
            owc_cnt     <= '0;
            fifo_cnt    <= '0;
            coll_cnt    <= '0;
            byte_cnt    <= '0;
            pkt_cnt     <= '0;
        end else begin
            clear_abort <= bad_path && info.abort;
            if (bad_path) begin
                err_cnt <= err_cnt + CNT_W'(1);
                if (info.crs) crs_cnt <= crs_cnt + CNT_W'(1);
                if (info.owc) owc_cnt <= owc_cnt + CNT_W'(1);
            end
            if (good_path) begin
                if (info.urun) fifo_cnt <= fifo_cnt + CNT_W'(1);
                coll_cnt <= coll_cnt + CNT_W'(info.coll);
                byte_cnt <= byte_cnt + BYTE_W'(info.bytes);
                pkt_cnt  <= pkt_cnt + CNT_W'(1);
            end
        end
    end

    p_abort_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_abort |-> $past(retire && info.abort));

    p_fault_no_pkt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && info.fault) |=> $stable(pkt_cnt));

    p_pkt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_cnt != $past(pkt_cnt)) |-> (pkt_cnt == $past(pkt_cnt) + CNT_W'(1)));

endmodule

// File: rtl/tx_slot_tracker.sv
module tx_slot_tracker
    import tx_trk_pkg::*;
#(
    parameter int SLOTS       = 4,
    parameter int LEN_W       = 11,
    parameter int MIN_LEN     = 60,
    parameter int INIT_THRESH = 256,
    parameter int CNT_W       = 16,
    parameter int BYTE_W      = 32,
    localparam int SLOT_W     = $clog2(SLOTS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    q_req,
    input  logic [LEN_W-1:0]        q_len,
    input  logic [SLOTS*STAT_W-1:0] slot_status,
    output logic                    cmd_valid,
    output logic [SLOT_W-1:0]       cmd_slot,
    output logic [STAT_W-1:0]       cmd_word,
    output logic                    q_full,
    output logic                    clear_abort,
    output logic [CNT_W-1:0]        err_cnt,
    output logic [CNT_W-1:0]        crs_cnt,
    output logic [CNT_W-1:0]        owc_cnt,
    output logic [CNT_W-1:0]        fifo_cnt,
    output logic [CNT_W-1:0]        coll_cnt,
    output logic [BYTE_W-1:0]       byte_cnt,
    output logic [CNT_W-1:0]        pkt_cnt
);

    logic              accept, retire, bump;
    logic [SLOT_W-1:0] prod_slot, ret_slot;
    logic [STAT_W-1:0] oldest_word;
    cpl_info_t         oldest_info;

    always_comb begin
        oldest_word = slot_status[ret_slot*STAT_W +: STAT_W];
        oldest_info = decode_status(oldest_word);
    end

    tx_ring_ctrl #(.SLOTS(SLOTS)) u_ring (
        .clk         (clk),
        .rst_n       (rst_n),
        .q_req       (q_req),
        .oldest_done (oldest_info.done),
        .accept      (accept),
        .retire      (retire),
        .prod_slot   (prod_slot),
        .ret_slot    (ret_slot),
        .full        (q_full)
    );

    tx_cmd_gen #(
        .SLOTS       (SLOTS),
        .LEN_W       (LEN_W),
        .MIN_LEN     (MIN_LEN),
        .INIT_THRESH (INIT_THRESH)
    ) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .q_len     (q_len),
        .prod_slot (prod_slot),
        .bump      (bump),
        .cmd_valid (cmd_valid),
        .cmd_slot  (cmd_slot),
        .cmd_word  (cmd_word)
    );

    tx_cpl_stats #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_stats (
        .clk          (clk),
        .rst_n        (rst_n),
        .retire       (retire),
        .info         (oldest_info),
        .underrun_evt (bump),
        .clear_abort  (clear_abort),
        .err_cnt      (err_cnt),
        .crs_cnt      (crs_cnt),
        .owc_cnt      (owc_cnt),
        .fifo_cnt     (fifo_cnt),
        .coll_cnt     (coll_cnt),
        .byte_cnt     (byte_cnt),
        .pkt_cnt      (pkt_cnt)
    );

    p_no_cmd_when_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && !retire) |=> !cmd_valid);

endmodule

// File: tb/tx_slot_tracker_bench.sv
module tx_slot_tracker_bench;

    localparam int CLK_P       = 10;
    localparam int SLOTS       = 4;
    localparam int LEN_W       = 11;
    localparam int CNT_W       = 16;
    localparam int BYTE_W      = 32;
    localparam int INIT_THRESH = 256;
    localparam int MIN_LEN     = 60;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  q_req = 1'b0;
    logic [LEN_W-1:0]      q_len = '0;
    logic [SLOTS*32-1:0]   slot_status;
    logic [31:0]           st [SLOTS];
    logic                  cmd_valid, q_full, clear_abort;
    logic [1:0]            cmd_slot;
    logic [31:0]           cmd_word;
    logic [CNT_W-1:0]      err_cnt, crs_cnt, owc_cnt, fifo_cnt, coll_cnt, pkt_cnt;
    logic [BYTE_W-1:0]     byte_cnt;

    int total = 0;
    int bad   = 0;
    logic [33:0] exp_q [$];
    int m_prod = 0, m_ret = 0;
    int m_thr = ((INIT_THRESH * 2048) & 32'h003f0000) / 65536;
    int m_err = 0, m_crs = 0, m_owc = 0, m_fifo = 0, m_coll = 0, m_bytes = 0, m_pkt = 0, m_abt = 0;
    int abt_seen = 0;

    always #(CLK_P/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < SLOTS; i++) slot_status[i*32 +: 32] = st[i];
    end

    tx_slot_tracker u_tx_slot_tracker (
        .clk(clk), .rst_n(rst_n), .q_req(q_req), .q_len(q_len),
        .slot_status(slot_status), .cmd_valid(cmd_valid), .cmd_slot(cmd_slot),
        .cmd_word(cmd_word), .q_full(q_full), .clear_abort(clear_abort),
        .err_cnt(err_cnt), .crs_cnt(crs_cnt), .owc_cnt(owc_cnt), .fifo_cnt(fifo_cnt),
        .coll_cnt(coll_cnt), .byte_cnt(byte_cnt), .pkt_cnt(pkt_cnt)
    );

    task automatic check(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected commands as the design produces them
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_valid) begin
                if (exp_q.size() == 0) begin
                    total++; bad++;
                    $display("FAIL R5 unexpected command actual=0x%0h expected=none", cmd_word);
                end else begin
                    logic [33:0] e;
                    e = exp_q.pop_front();
                    check("R2 slot", cmd_slot, e[33:32]);
                    check("R3/R4 word", cmd_word, e[31:0]);
                end
            end
            if (clear_abort) abt_seen++;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: pushes the expected command, then drives the request
    task automatic queue_frame(input int len);
        int pad, slot;
        @(negedge clk);
        if ((m_prod - m_ret) < SLOTS) begin
            slot = m_prod % SLOTS;
            pad  = (len < MIN_LEN) ? MIN_LEN : len;
            st[slot] = 32'h0;
            exp_q.push_back({slot[1:0], 32'(m_thr << 16) | 32'(pad)});
            m_prod++;
        end
        q_req = 1'b1;
        q_len = LEN_W'(len);
        @(negedge clk);
        q_req = 1'b0;
    endtask

    task automatic model_retire(input logic [31:0] w);
        m_ret++;
        if (w[30] || w[29]) begin
            m_err++;
            if (w[31]) m_crs++;
            if (w[29]) m_owc++;
            if (w[30]) m_abt++;
        end else begin
            if (w[14]) begin
                m_fifo++;
                if (m_thr < 48) m_thr += 2;
            end
            m_coll  += int'(w[27:24]);
            m_bytes += int'(w[10:0]);
            m_pkt++;
        end
    endtask

    task automatic check_counters(input string req);
        check({req, " err"},   err_cnt,  m_err);
        check({req, " crs"},   crs_cnt,  m_crs);
        check({req, " owc"},   owc_cnt,  m_owc);
        check({req, " fifo"},  fifo_cnt, m_fifo);
        check({req, " coll"},  coll_cnt, m_coll);
        check({req, " bytes"}, byte_cnt, m_bytes);
        check({req, " pkts"},  pkt_cnt,  m_pkt);
        check({req, " abort pulses"}, abt_seen, m_abt);
    endtask

    function automatic logic [31:0] good_word(input int coll, input int bytes, input bit urun);
        logic [31:0] w;
        w = 32'h0;
        w[15] = ~urun;
        w[14] = urun;
        w[27:24] = 4'(coll);
        w[10:0] = 11'(bytes);
        return w;
    endfunction

    initial begin
        #(CLK_P * 150000);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] w0, w1, wa, wo;
        for (int i = 0; i < SLOTS; i++) st[i] = 32'h0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        check("R1 full", q_full, 0);
        check("R1 cmd_valid", cmd_valid, 0);
        check("R1 clear_abort", clear_abort, 0);
        check_counters("R1");

        // R2 R3 R4: short, exact minimum and long frames
        queue_frame(10);
        queue_frame(60);
        queue_frame(1514);
        check("R5 not full at 3", q_full, 0);
        queue_frame(59);
        check("R5 full at 4", q_full, 1);
        // R5 request while full is ignored
        queue_frame(200);
        idle(2);
        check("R5 still full", q_full, 1);
        check("R5 no extra command", exp_q.size(), 0);

        // R6 slot 1 finished behind unfinished slot 0
        w1 = good_word(0, 60, 0);
        @(negedge clk); st[1] = w1;
        idle(4);
        check("R6 no out-of-order retire", pkt_cnt, 0);
        check("R6 still full", q_full, 1);
        w0 = good_word(3, 42, 0);
        @(negedge clk); st[0] = w0;
        @(negedge clk);
        check("R10 full drops after retire", q_full, 0);
        idle(3);
        model_retire(w0);
        model_retire(w1);
        check_counters("R9");

        // R7 abort with carrier lost, and late window with good bit set
        wa = 32'hC000_0000 | 32'd77;
        wo = 32'h2000_8000 | 32'h0300_0000 | 32'd99;
        @(negedge clk); st[2] = wa; st[3] = wo;
        idle(4);
        model_retire(wa);
        model_retire(wo);
        check_counters("R7");
        check("R1 empty after drain", q_full, 0);

        // R8 repeated underruns walk the threshold up to the cap
        for (int k = 0; k < 22; k++) begin
            logic [31:0] wu;
            int s;
            s = m_prod % SLOTS;
            queue_frame(100 + k);
            wu = good_word(1, 100 + k, 1);
            @(negedge clk); st[s] = wu;
            idle(3);
            model_retire(wu);
        end
        check("R8 threshold capped", m_thr, 48);
        check_counters("R8");
        // R4 command after the cap carries field 48
        queue_frame(30);
        idle(2);
        check("R2 all commands seen", exp_q.size(), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule